// File: doc/BRIEF.md
# General-Purpose I/O Port with Edge-Sensitive External Interrupt

This block is one parallel I/O port of `WIDTH` pins, controlled through a small register interface. Each pin is set up by three bits: a direction bit, an output latch bit and an option bit. With the direction bit set, the pin is an output and the option bit picks its drive: push-pull when set, open-drain when clear. With the direction bit clear, the pin is an input and the option bit arms that pin as a source of the port's external interrupt. Reading the latch register returns the stored bits and never the level on the pad. A separate read-only register returns the synchronized pad level.

Pad inputs pass through a synchronizer before reaching an edge detector. One 2-bit sensitivity field, shared by the whole port, sets the detector's sensitivity. Any detected event sets a sticky pending bit that drives the port's interrupt request. Software clears the bit by writing a one to it. When a pin's interrupt is disarmed, the detector sees a constant logic 1 on that pin instead of the pad. Arming or disarming a pin while its pad is low therefore produces a real, detectable transition. Drivers must use a safe sensitivity during that change: rising while arming, falling while disarming. The block models this side effect exactly.

Top module: `gpio_xint_port`

## Requirements
- R1: After reset, direction, latch, option, sensitivity and pending all read zero, no pin is driven (`pin_oe` all zero) and `irq` is low.
- R2: A pin with direction=1 and option=1 is push-pull: `pin_oe`=1 and `pin_out` equals the latch bit.
- R3: A pin with direction=1 and option=0 is open-drain: latch 0 gives `pin_oe`=1 with `pin_out`=0, and latch 1 gives `pin_oe`=0 (floating).
- R4: A pin with direction=0 is never driven (`pin_oe`=0), whatever its latch and option bits are.
- R5: Reading address 1 returns the stored latch value, not the pad level. Reading address 5 returns the pad level as it stood SYNC_STAGES clock edges earlier.
- R6: A pin's interrupt is armed when its direction=0 and option=1. With the default SYNC_STAGES=2, a qualifying pad edge makes `irq` rise on the third rising clock edge after the pad changes, and not before.
- R7: The sensitivity field (address 3, bits 1:0) selects: 00 falling edges only, 01 rising edges only, 10 both edges, 11 falling edge or low level. A low level keeps re-setting pending for as long as the pad stays low.
- R8: A disarmed pin presents logic 1 to the detector. Arming a pin whose pad is low therefore makes a falling event, and disarming it makes a rising event. Either event sets pending when the sensitivity includes that edge.
- R9: Arming a low pin while sensitivity 01 is selected, or disarming it while 00 is selected, leaves pending clear.
- R10: Pending (address 4, bit 0) is sticky. A write to address 4 with bit 0 set clears it. A write with bit 0 clear has no effect. An event in the same cycle as a clear keeps it set.
- R11: Register map: 0 direction, 1 latch, 2 option, 3 sensitivity, 4 pending, 5 pad level (read-only). Writes to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr` (combinational) |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| pin_oe | output | WIDTH | Pad output enable, one per pin |
| pin_out | output | WIDTH | Pad output value, one per pin |
| irq | output | 1 | Port interrupt request (pending bit) |

## Verification
The drive logic is tried with every combination of direction, option and latch bits over a mixed latch pattern. This separates push-pull from open-drain and from input mode, pin by pin. The detector is exercised with single pad edges in each of the four sensitivity codes. Each code is shown to react to its own edge and to ignore the opposite one. A held low level tells level mode apart from plain falling mode. The arm and disarm sequences are then run with the pad held low, once under an unsafe sensitivity and once under a safe one. Only the forced detector input can tell those two runs apart.

// File: rtl/gpio_xint_pkg.sv
package gpio_xint_pkg;

   typedef enum logic [1:0] {
      SENS_FALL     = 2'b00,
      SENS_RISE     = 2'b01,
      SENS_BOTH     = 2'b10,
      SENS_FALL_LOW = 2'b11
   } sens_e;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADR_DIR  = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_LAT  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_OPT  = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_SENS = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_PEND = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_PIN  = 3'd5;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_xint_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr,
   input  logic [WIDTH-1:0]    wdata,
   input  logic                evt_any,
   input  logic [WIDTH-1:0]    pin_lvl,
   output logic [WIDTH-1:0]    dir_q,
   output logic [WIDTH-1:0]    lat_q,
   output logic [WIDTH-1:0]    opt_q,
   output sens_e               sens_q,
   output logic                pend_q,
   output logic [WIDTH-1:0]    rdata
);

   localparam int unsigned PAD_W = WIDTH - 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("gpio_port_regs: WIDTH must be at least 2");
   end

   logic wr_dir, wr_lat, wr_opt, wr_sens, clr_pend;

   always_comb begin
      wr_dir   = wr && (addr == ADR_DIR);
      wr_lat   = wr && (addr == ADR_LAT);
      wr_opt   = wr && (addr == ADR_OPT);
      wr_sens  = wr && (addr == ADR_SENS);
      clr_pend = wr && (addr == ADR_PEND) && wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         lat_q  <= '0;
         opt_q  <= '0;
         sens_q <= SENS_FALL;
      end else begin
         if (wr_dir)  dir_q  <= wdata;
         if (wr_lat)  lat_q  <= wdata;
         if (wr_opt)  opt_q  <= wdata;
         if (wr_sens) sens_q <= sens_e'(wdata[1:0]);
      end
   end

   // set has priority over the write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (evt_any)  pend_q <= 1'b1;
      else if (clr_pend) pend_q <= 1'b0;
   end

   always_comb begin
      unique case (addr)
         ADR_DIR:  rdata = dir_q;
         ADR_LAT:  rdata = lat_q;
         ADR_OPT:  rdata = opt_q;
         ADR_SENS: rdata = {{PAD_W{1'b0}}, sens_q};
         ADR_PEND: rdata = {{(WIDTH-1){1'b0}}, pend_q};
         ADR_PIN:  rdata = pin_lvl;
         default:  rdata = '0;
      endcase
   end

   // R10: pending holds until cleared
   a_r10_pend_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(wr && addr == ADR_PEND && wdata[0])) |=> pend_q);

   // R10: a clear without a competing event empties pending
   a_r10_clear_works : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADR_PEND && wdata[0] && !evt_any) |=> !pend_q);

   // R11: writes to the read-only and unused addresses change nothing
   a_r11_ro_writes : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr >= ADR_PIN) |=>
         ($stable(dir_q) && $stable(lat_q) && $stable(opt_q) && $stable(sens_q)));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] opt_q,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
         if (!dir_q[b]) begin
            pad_oe[b]  = 1'b0;
            pad_out[b] = 1'b0;
         end else if (opt_q[b]) begin
            pad_oe[b]  = 1'b1;        // push-pull
            pad_out[b] = lat_q[b];
         end else begin
            pad_oe[b]  = ~lat_q[b];   // open-drain: only pull low
            pad_out[b] = lat_q[b];
         end
      end
   end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
   import gpio_xint_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   input  logic [WIDTH-1:0] arm_mask,
   input  sens_e            sens,
   output logic [WIDTH-1:0] pin_lvl,
   output logic             evt_any
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_edge_detect: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] sync_q [SYNC_STAGES];
   logic [WIDTH-1:0] gated, gated_q, evt_vec;
   logic [WIDTH-1:0] arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= '1;
      else        sync_q[0] <= pin_in;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= '1;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   assign pin_lvl = sync_q[LAST];

   // disarmed pins present a constant 1 to the detector
   assign gated = sync_q[LAST] | ~arm_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gated_q <= '1;
         arm_q   <= '0;
      end else begin
         gated_q <= gated;
         arm_q   <= arm_mask;
      end
   end

   always_comb begin
      unique case (sens)
         SENS_FALL:     evt_vec = gated_q & ~gated;
         SENS_RISE:     evt_vec = ~gated_q & gated;
         SENS_BOTH:     evt_vec = gated_q ^ gated;
         SENS_FALL_LOW: evt_vec = ~gated;
         default:       evt_vec = '0;
      endcase
   end

   assign evt_any = |evt_vec;

   // R8: a pin disarmed now and one cycle ago cannot raise an event
   a_r8_disarmed_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_vec & ~arm_mask & ~arm_q) == '0));

   // R7: rising-only sensitivity never reacts to a low synchronized pad on an armed, steady pin
   a_r7_rise_ignores_low : assert property (@(posedge clk) disable iff (!rst_n)
      (sens == SENS_RISE) |-> ((evt_vec & ~gated) == '0));

endmodule

// File: rtl/gpio_xint_port.sv
module gpio_xint_port
   import gpio_xint_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic             irq
);

   logic [WIDTH-1:0] dir_q, lat_q, opt_q, pin_lvl, arm_mask;
   sens_e            sens_q;
   logic             pend_q, evt_any;

   assign arm_mask = ~dir_q & opt_q;

   gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .evt_any (evt_any),
      .pin_lvl (pin_lvl),
      .dir_q   (dir_q),
      .lat_q   (lat_q),
      .opt_q   (opt_q),
      .sens_q  (sens_q),
      .pend_q  (pend_q),
      .rdata   (bus_rdata)
   );

   gpio_pad_drive #(.WIDTH(WIDTH)) drive_i (
      .dir_q   (dir_q),
      .lat_q   (lat_q),
      .opt_q   (opt_q),
      .pad_oe  (pin_oe),
      .pad_out (pin_out)
   );

   gpio_edge_detect #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .arm_mask (arm_mask),
      .sens     (sens_q),
      .pin_lvl  (pin_lvl),
      .evt_any  (evt_any)
   );

   assign irq = pend_q;

   // R4: input pins are never driven
   a_r4_input_undriven : assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~dir_q) == '0));

   // R3: open-drain pins holding a 1 float
   a_r3_od_high_floats : assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & dir_q & ~opt_q & lat_q) == '0));

   // R2: push-pull outputs always drive
   a_r2_pp_drives : assert property (@(posedge clk) disable iff (!rst_n)
      ((~pin_oe & dir_q & opt_q) == '0));

endmodule

// File: tb/gpio_xint_port_tb.sv
module gpio_xint_port_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pin_in = '1;
   logic [W-1:0] pin_oe, pin_out;
   logic         irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   gpio_xint_port #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq));

   // ---------------- behavioural reference ----------------
   logic [W-1:0] m_dir, m_lat, m_opt, m_prev;
   logic [1:0]   m_sens;
   logic         m_pend;
   logic [W-1:0] hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dir = '0; m_lat = '0; m_opt = '0; m_sens = 2'b00; m_pend = 1'b0;
         m_prev = '1;
         hist = {};
         hist.push_back('1); hist.push_back('1);
      end else begin
         logic [W-1:0] seen;
         logic ev;
         ev = 1'b0;
         for (int i = 0; i < W; i++) begin
            seen[i] = (!m_dir[i] && m_opt[i]) ? hist[0][i] : 1'b1;
            case (m_sens)
               2'b00: if (m_prev[i] && !seen[i]) ev = 1'b1;
               2'b01: if (!m_prev[i] && seen[i]) ev = 1'b1;
               2'b10: if (m_prev[i] != seen[i]) ev = 1'b1;
               default: if (!seen[i]) ev = 1'b1;
            endcase
         end
         if (ev) m_pend = 1'b1;
         else if (bus_wr && bus_addr == 3'd4 && bus_wdata[0]) m_pend = 1'b0;
         m_prev = seen;
         hist.push_back(pin_in);
         void'(hist.pop_front());
         if (bus_wr) begin
            case (bus_addr)
               3'd0: m_dir = bus_wdata;
               3'd1: m_lat = bus_wdata;
               3'd2: m_opt = bus_wdata;
               3'd3: m_sens = bus_wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3", "pin_oe vs model", pin_oe, m_dir & (m_opt | ~m_lat));
         chk("R2", "pin_out vs model", pin_out & pin_oe, m_dir & m_lat & pin_oe);
         chk("R6", "irq vs model", {7'd0, irq}, {7'd0, m_pend});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
      #1;
   endtask

   logic [W-1:0] rv;

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1", "oe after reset", pin_oe, '0);
      chk("R1", "irq after reset", {7'd0, irq}, '0);
      for (int a = 0; a < 5; a++) begin
         rd(a[2:0], rv); chk("R1", "register after reset", rv, '0);
      end

      // R2 push-pull
      wr(3'd1, 8'hA5); wr(3'd2, 8'hFF); wr(3'd0, 8'hFF);
      chk("R2", "push-pull oe", pin_oe, 8'hFF);
      chk("R2", "push-pull out", pin_out, 8'hA5);
      // R3 open-drain on upper nibble (latch A = 1010)
      wr(3'd2, 8'h0F);
      chk("R3", "open-drain oe", pin_oe, 8'h5F);
      chk("R3", "open-drain low out", pin_out & pin_oe, 8'h05);
      // R4 input mode
      wr(3'd0, 8'h00);
      chk("R4", "input oe", pin_oe, 8'h00);
      // R5 latch vs pad
      pin_in = 8'h3C;
      cyc(3);
      rd(3'd1, rv); chk("R5", "latch readback", rv, 8'hA5);
      rd(3'd5, rv); chk("R5", "pad level read", rv, 8'h3C);
      pin_in = 8'hFF;
      wr(3'd2, 8'h00); wr(3'd1, 8'h00);
      cyc(4);
      wr(3'd4, 8'h01);   // drop anything the pad test caused
      cyc(1);

      // R6 / R7 rising only, safe arm with pad high
      wr(3'd3, 8'h01); wr(3'd2, 8'h01);
      cyc(4); chk("R9", "arm with pad high", {7'd0, irq}, '0);
      pin_in = 8'hFE; cyc(4);
      chk("R7", "rising ignores fall", {7'd0, irq}, '0);
      pin_in = 8'hFF; cyc(2);
      chk("R6", "irq not before third edge", {7'd0, irq}, '0);
      cyc(1);
      chk("R6", "irq on third edge", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h00);
      chk("R10", "write zero keeps pending", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      chk("R10", "write one clears", {7'd0, irq}, '0);

      // R7 falling only
      wr(3'd3, 8'h00); pin_in = 8'hFE; cyc(4);
      chk("R7", "falling mode", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      // R7 both edges
      wr(3'd3, 8'h02); pin_in = 8'hFF; cyc(4);
      chk("R7", "both mode rise", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      pin_in = 8'hFE; cyc(4);
      chk("R7", "both mode fall", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      chk("R7", "both mode cleared", {7'd0, irq}, '0);
      // R7 level low, R10 set wins over clear
      wr(3'd3, 8'h03); cyc(2);
      chk("R7", "low level sets", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      chk("R10", "event beats clear", {7'd0, irq}, 8'h01);
      wr(3'd3, 8'h01); pin_in = 8'hFF; cyc(4);
      wr(3'd4, 8'h01);
      chk("R7", "level mode released", {7'd0, irq}, '0);

      // R8 spurious events with pad low
      pin_in = 8'hFE; cyc(4);
      chk("R7", "rising mode pad low", {7'd0, irq}, '0);
      wr(3'd2, 8'h00); cyc(1);
      chk("R8", "disarm while low, rising", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      wr(3'd3, 8'h00); wr(3'd2, 8'h01); cyc(1);
      chk("R8", "arm while low, falling", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h01);
      chk("R8", "cleared", {7'd0, irq}, '0);

      // R9 safe sequences with pad low
      wr(3'd2, 8'h00); cyc(2);
      chk("R9", "disarm under falling", {7'd0, irq}, '0);
      wr(3'd3, 8'h01); wr(3'd2, 8'h01); cyc(2);
      chk("R9", "arm under rising", {7'd0, irq}, '0);

      // R11 writes to read-only/unused addresses
      wr(3'd5, 8'h55); wr(3'd6, 8'hAA); wr(3'd7, 8'h33);
      rd(3'd0, rv); chk("R11", "dir untouched", rv, 8'h00);
      rd(3'd1, rv); chk("R11", "latch untouched", rv, 8'h00);
      rd(3'd2, rv); chk("R11", "option untouched", rv, 8'h01);
      rd(3'd3, rv); chk("R11", "sens untouched", rv, 8'h01);
      rd(3'd7, rv); chk("R11", "unused reads zero", rv, 8'h00);

      cyc(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule